// File: doc/BRIEF.md
# Processor Clock, Reset and Ready Generator

This block derives the timing signals a 16-bit microprocessor bus needs from one fast oscillator. It divides the oscillator by three to make the processor clock. It halves that again to make a peripheral clock. It stretches a raw reset request into a reset that the processor can use. It also combines two bus-slave ready indications into one ready that is aligned to the processor clock. Every flip-flop runs on the oscillator. The processor-clock edges are internal enables, so the outputs never pass through a gated or derived clock net.

A raw reset request arrives as a clean digital level. It is sampled on processor-clock falling edges, and the reset output follows it only on those edges. After the request drops, the reset output stays high for a parameterised number of processor-clock periods. Each ready source has its own active-low enable. A source counts only while its enable is low. The combined result passes through two stages that sample on processor-clock rising edges. While the ready output is low, the processor stretches its current bus cycle.

Top module: `cpu_clkgen`

## Requirements
- R1: `clk_o` has a period of exactly 3 oscillator cycles and is high for 1 of them and low for 2.
- R2: `pclk_o` has a period of exactly 6 oscillator cycles, 3 high and 3 low, so it is `clk_o` divided by two.
- R3: `pclk_o` changes only in an oscillator cycle where `clk_o` rises.
- R4: `reset_o` is high from power-up.
- R5: A reset request held high for at least one `clk_o` period drives `reset_o` high within 3 `clk_o` falling edges, and `reset_o` stays high while the request is held.
- R6: After the request drops, `reset_o` stays high for between HOLD_CYCLES and HOLD_CYCLES+3 `clk_o` rising edges (default HOLD_CYCLES = 4), and then goes low.
- R7: `reset_o` changes only in an oscillator cycle where `clk_o` falls.
- R8: The combined ready is `(rdy_a_i & ~aen_a_n_i) | (rdy_b_i & ~aen_b_n_i)`. A source whose enable is high (1) has no effect on `ready_o`.
- R9: A change on the ready inputs that is applied between two `clk_o` rising edges shows on `ready_o` after exactly the second following `clk_o` rise, and not after the first.
- R10: `ready_o` changes only in an oscillator cycle where `clk_o` rises.
- R11: `clk_o` and `pclk_o` keep their R1 and R2 waveforms while a reset request is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| osc_i | input | 1 | Oscillator clock; all logic runs on its rising edge |
| rst_req_i | input | 1 | Raw reset request, active high, clean digital level |
| rdy_a_i | input | 1 | Ready from slave A, active high |
| aen_a_n_i | input | 1 | Enable for slave A ready, active low |
| rdy_b_i | input | 1 | Ready from slave B, active high |
| aen_b_n_i | input | 1 | Enable for slave B ready, active low |
| clk_o | output | 1 | Processor clock, oscillator / 3, one-third duty |
| pclk_o | output | 1 | Peripheral clock, processor clock / 2 |
| reset_o | output | 1 | Processor reset, active high, changes on clk_o falls |
| ready_o | output | 1 | Synchronized ready, changes on clk_o rises |

## Verification
The hardest case to produce is the exact ready latency. A new ready input must stay invisible after one processor-clock rise and appear after the second. This only shows up when the inputs change between rises, at a known point in the three-cycle phase. The stimulus waits until it sees a `clk_o` rise at the pins, then changes the ready inputs in the next oscillator low phase. It checks the output after one rise and again after two rises. This is done for all sixteen input combinations and then for a run of seeded random patterns. The reset stretch gets similar care: the bench counts `clk_o` rises from the drop of the request until `reset_o` falls.

// File: rtl/cpu_clkgen.sv
module cpu_clkgen #(
  parameter int HOLD_CYCLES = 4
) (
  input  logic osc_i,
  input  logic rst_req_i,
  input  logic rdy_a_i,
  input  logic aen_a_n_i,
  input  logic rdy_b_i,
  input  logic aen_b_n_i,
  output logic clk_o,
  output logic pclk_o,
  output logic reset_o,
  output logic ready_o
);
  localparam int CW = $clog2(HOLD_CYCLES + 1);

  logic [1:0]    ph    = 2'd0;
  logic          clk_q = 1'b0;
  logic          pck_q = 1'b0;
  logic          rq_s1 = 1'b1;
  logic          rq_s2 = 1'b1;
  logic          rst_q = 1'b1;
  logic [CW-1:0] hold  = '0;
  logic          rd_s1 = 1'b0;
  logic          rd_s2 = 1'b0;

  wire rise_en = (ph == 2'd2);
  wire fall_en = (ph == 2'd0);
  wire rdy_any = (rdy_a_i & ~aen_a_n_i) | (rdy_b_i & ~aen_b_n_i);

  always_ff @(posedge osc_i) begin
    ph    <= rise_en ? 2'd0 : ph + 2'd1;
    clk_q <= rise_en;
    if (rise_en) pck_q <= ~pck_q;
  end

  always_ff @(posedge osc_i) begin
    if (fall_en) begin
      rq_s1 <= rst_req_i;
      rq_s2 <= rq_s1;
      if (rq_s2) begin
        rst_q <= 1'b1;
        hold  <= '0;
      end else if (rst_q) begin
        if (hold == CW'(HOLD_CYCLES - 1)) rst_q <= 1'b0;
        else hold <= hold + 1'b1;
      end
    end
  end

  always_ff @(posedge osc_i) begin
    if (rise_en) begin
      rd_s1 <= rdy_any;
      rd_s2 <= rd_s1;
    end
  end

  assign clk_o   = clk_q;
  assign pclk_o  = pck_q;
  assign reset_o = rst_q;
  assign ready_o = rd_s2;
endmodule

// File: rtl/cpu_clkgen_chk.sv
module cpu_clkgen_chk (
  input logic osc_i,
  input logic clk_o,
  input logic pclk_o,
  input logic reset_o,
  input logic ready_o
);
  logic live = 1'b0;
  always_ff @(posedge osc_i) live <= 1'b1;

  a_r1_clk_high_one: assert property (@(posedge osc_i) disable iff (!live)
    $rose(clk_o) |=> !clk_o);
  a_r1_clk_low_two: assert property (@(posedge osc_i) disable iff (!live)
    $fell(clk_o) |=> !clk_o ##1 clk_o);
  a_r3_pclk_on_rise: assert property (@(posedge osc_i) disable iff (!live)
    (pclk_o != $past(pclk_o)) |-> $rose(clk_o));
  a_r7_reset_on_fall: assert property (@(posedge osc_i) disable iff (!live)
    (reset_o != $past(reset_o)) |-> $fell(clk_o));
  a_r10_ready_on_rise: assert property (@(posedge osc_i) disable iff (!live)
    (ready_o != $past(ready_o)) |-> $rose(clk_o));
endmodule

bind cpu_clkgen cpu_clkgen_chk u_chk (
  .osc_i(osc_i), .clk_o(clk_o), .pclk_o(pclk_o),
  .reset_o(reset_o), .ready_o(ready_o)
);

// File: tb/sim_cpu_clkgen.sv
`timescale 1ns/1ps
module sim_cpu_clkgen;
  localparam int HOLD = 4;

  logic osc = 1'b0;
  logic rst_req = 1'b0;
  logic rdy_a = 1'b0, aen_a_n = 1'b1, rdy_b = 1'b0, aen_b_n = 1'b1;
  logic clk, pclk, reset, ready;
  int n_cmp = 0, n_bad = 0;
  bit done = 1'b0;
  bit last_exp = 1'b0;

  always #2.5 osc = ~osc;

  cpu_clkgen #(.HOLD_CYCLES(HOLD)) u0 (
    .osc_i(osc), .rst_req_i(rst_req), .rdy_a_i(rdy_a), .aen_a_n_i(aen_a_n),
    .rdy_b_i(rdy_b), .aen_b_n_i(aen_b_n), .clk_o(clk), .pclk_o(pclk),
    .reset_o(reset), .ready_o(ready)
  );

  function automatic bit exp_ready(bit ra, bit ea, bit rb, bit eb);
    return (ra && !ea) || (rb && !eb);
  endfunction

  task automatic check(string req, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_rise();
    bit p;
    do begin
      p = clk;
      @(negedge osc);
    end while (!(clk && !p));
  endtask

  task automatic measure(string req);
    int per, hi, pper, phi;
    wait_rise();
    per = 0; hi = 0;
    do begin
      if (clk) hi++;
      per++;
      @(negedge osc);
    end while (!(clk && per > 0 && hi > 0 && per >= 3) && per < 20);
    check({req, " clk period"}, per, 3);
    check({req, " clk high"}, hi, 1);
    while (!(pclk && clk)) @(negedge osc);
    pper = 0; phi = 0;
    do begin
      if (pclk) phi++;
      pper++;
      @(negedge osc);
    end while (!(pclk && clk && pper >= 3) && pper < 30);
    check({req, " pclk period"}, pper, 6);
    check({req, " pclk high"}, phi, 3);
  endtask

  task automatic ready_step(bit ra, bit ea, bit rb, bit eb);
    bit e;
    wait_rise();
    rdy_a = ra; aen_a_n = ea; rdy_b = rb; aen_b_n = eb;
    e = exp_ready(ra, ea, rb, eb);
    wait_rise();
    check("R9 ready held after one rise", ready, last_exp);
    wait_rise();
    check("R8 R9 ready after two rises", ready, e);
    last_exp = e;
  endtask

  initial begin
    #1ms;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    int seed, cnt, k;
    seed = $urandom(32'd4242);
    @(negedge osc);
    check("R4 reset at power-up", reset, 1);
    measure("R1 R2");

    cnt = 0;
    while (reset && cnt < 40) begin wait_rise(); cnt++; end
    check("R6 power-up reset releases", reset, 0);

    for (int i = 0; i < 16; i++)
      ready_step(i[0], i[1], i[2], i[3]);
    for (int i = 0; i < 40; i++)
      ready_step($urandom % 2, $urandom % 2, $urandom % 2, $urandom % 2);

    for (int t = 0; t < 2; t++) begin
      wait_rise();
      rst_req = 1'b1;
      for (int j = 0; j < 3; j++) wait_rise();
      check("R5 reset follows request", reset, 1);
      measure("R11 during reset");
      k = 2 + t * 5;
      for (int j = 0; j < k; j++) begin
        wait_rise();
        check("R5 reset held with request", reset, 1);
      end
      @(negedge osc);
      rst_req = 1'b0;
      cnt = 0;
      while (cnt < 20) begin
        wait_rise();
        if (!reset) break;
        cnt++;
      end
      n_cmp++;
      if (cnt < HOLD || cnt > HOLD + 3) begin
        n_bad++;
        $display("FAIL R6 stretch rises actual=%0d expected=%0d..%0d", cnt, HOLD, HOLD + 3);
      end
      ready_step(1, 0, 0, 1);
      ready_step(0, 1, 1, 1);
    end

    for (int j = 0; j < 12; j++) begin
      bit pc, pp, pr;
      pc = clk; pp = pclk; pr = reset;
      @(negedge osc);
      if (pp != pclk) check("R3 pclk moves with clk rise", int'(clk && !pc), 1);
      if (pr != reset) check("R7 reset moves with clk fall", int'(!clk && pc), 1);
    end
    check("R10 ready stable", ready, last_exp);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule